// File: doc/BRIEF.md
# SDRAM Chip-Select Region Decoder

This block turns a bus address into a chip-select decision across four external SDRAM regions. Each region is described by one 32-bit configuration word. That word packs three things: a base address aligned to 4 KB, an exponential size code and an enable flag. Software or boot logic loads the words through a simple write port. After that, every address presented on the lookup port produces a registered result one clock later.

The result has four parts:
- a one-hot chip select naming the region that matched;
- the byte offset of the address inside that region;
- a miss flag, raised when no enabled region covers the address;
- an overlap flag, raised when more than one region covers the address.

When regions overlap, the lowest-numbered region takes the access. The block sits in front of the SDRAM command engine, which consumes the chip select and the offset.

Top module: `sdram_region_decoder`

## Requirements
- R1: After reset every region is disabled, and `res_valid`, `cs`, `offset`, `miss` and `overlap` are all zero.
- R2: A write with `cfg_we` high loads region `cfg_idx` from `cfg_data`. The fields are: base from bits 31:12, size code from bits 5:1, enable from bit 0. Bits 11:6 are ignored. The new contents apply to lookups presented in the cycle after the write. A lookup presented in the same cycle as the write still sees the old contents.
- R3: Region size is 4 KB × 2^code. An address falls in a region when the address bits at and above position 12+code equal the base bits at those positions. Base bits below the region size do not matter.
- R4: A region whose enable bit is 0 never matches.
- R5: A region whose size code is above 20 (0x14) never matches, whatever its enable bit.
- R6: One cycle after a cycle with `lookup_valid` high, `res_valid` is 1, and `cs` bit i is set when region i wins. `offset` equals the address modulo the winning region's size.
- R7: When several regions match, the lowest index wins and `overlap` is 1. With exactly one match, `overlap` is 0.
- R8: When no region matches, the result has `miss`=1, `cs`=0 and `offset`=0.
- R9: One cycle after a cycle with `lookup_valid` low, `res_valid`, `cs`, `offset`, `miss` and `overlap` are all zero.
- R10: Size code 20 covers the whole 4 GB space, so `offset` equals the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Region configuration write strobe |
| cfg_idx | input | 2 | Region index to write |
| cfg_data | input | 32 | Packed base / size code / enable word |
| lookup_valid | input | 1 | Address presented this cycle |
| lookup_addr | input | 32 | Address to decode |
| res_valid | output | 1 | Result of previous cycle's lookup is present |
| cs | output | 4 | One-hot region select |
| offset | output | 32 | Offset within winning region |
| miss | output | 1 | No region matched |
| overlap | output | 1 | Two or more regions matched |

## Verification
All results are due one clock after the lookup cycle, because the decode is combinational into a single output register. Configuration changes become visible to lookups presented one cycle after the write cycle.

The bench therefore drives each input on a falling edge and samples the outputs on the following falling edge. At that point exactly one rising edge has passed. For the write/lookup collision, the expected value is computed from the configuration as it stood before the write. A sample taken one further cycle later confirms that the result clears when no lookup follows.

// File: rtl/sdram_region_decoder.sv
module sdram_region_decoder #(
  parameter int ADDR_W = 32,
  parameter int NREG   = 4,
  parameter int PAGE_W = 12,
  parameter int CODE_W = 5,
  parameter int IDX_W  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [ADDR_W-1:0] cfg_data,
  input  logic              lookup_valid,
  input  logic [ADDR_W-1:0] lookup_addr,
  output logic              res_valid,
  output logic [NREG-1:0]   cs,
  output logic [ADDR_W-1:0] offset,
  output logic              miss,
  output logic              overlap
);
  localparam int MAX_CODE = ADDR_W - PAGE_W;
  localparam int BASE_W   = ADDR_W - PAGE_W;

  logic [BASE_W-1:0] base_q [NREG];
  logic [CODE_W-1:0] code_q [NREG];
  logic [NREG-1:0]   en_q;
  logic [NREG-1:0]   hit;
  logic [ADDR_W-1:0] mask [NREG];

  wire unused_cfg_bits = ^cfg_data[PAGE_W-1:CODE_W+1];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[i] <= '0;
        code_q[i] <= '0;
        en_q[i]   <= 1'b0;
      end else if (cfg_we && cfg_idx == IDX_W'(i)) begin
        base_q[i] <= cfg_data[ADDR_W-1:PAGE_W];
        code_q[i] <= cfg_data[CODE_W:1];
        en_q[i]   <= cfg_data[0];
      end
    end

    assign mask[i] = ~({ADDR_W{1'b1}} << (PAGE_W + int'(code_q[i])));
    assign hit[i]  = en_q[i] && (int'(code_q[i]) <= MAX_CODE) &&
                     ((lookup_addr & ~mask[i]) == ({base_q[i], {PAGE_W{1'b0}}} & ~mask[i]));
  end

  logic [NREG-1:0]   win;
  logic [ADDR_W-1:0] win_mask;

  always_comb begin
    win      = '0;
    win_mask = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (hit[i]) begin
        win      = '0;
        win[i]   = 1'b1;
        win_mask = mask[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !lookup_valid) begin
      res_valid <= 1'b0;
      cs        <= '0;
      offset    <= '0;
      miss      <= 1'b0;
      overlap   <= 1'b0;
    end else begin
      res_valid <= 1'b1;
      cs        <= win;
      offset    <= lookup_addr & win_mask;
      miss      <= (hit == '0);
      overlap   <= ($countones(hit) > 1);
    end
  end

  p_cs_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(cs))
    else $error("cs not one-hot");
  p_valid_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_valid |=> res_valid)
    else $error("res_valid missing");
  p_miss_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> (cs == '0 && offset == '0 && !overlap && res_valid))
    else $error("miss with select");
  p_overlap_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    overlap |-> (cs != '0 && !miss))
    else $error("overlap without winner");
  p_result_decided_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (miss ^ (cs != '0)))
    else $error("result neither hit nor miss");
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (cs == '0 && !miss && !overlap && offset == '0))
    else $error("idle output not zero");
endmodule

// File: tb/sdram_region_decoder_test.sv
module sdram_region_decoder_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [1:0]  cfg_idx = 0;
  logic [31:0] cfg_data = 0;
  logic        lookup_valid = 0;
  logic [31:0] lookup_addr = 0;
  logic        res_valid;
  logic [3:0]  cs;
  logic [31:0] offset;
  logic        miss, overlap;

  int checks = 0, fails = 0;
  logic [31:0] m_base [4];
  int          m_code [4];
  bit          m_en   [4];

  always #5 clk = ~clk;

  sdram_region_decoder uut (.*);

  task automatic check(string req, logic [3:0] a_cs, logic [31:0] a_off, bit a_miss,
                       bit a_ov, bit a_rv, logic [3:0] e_cs, logic [31:0] e_off,
                       bit e_miss, bit e_ov, bit e_rv);
    checks++;
    if (a_cs !== e_cs || a_off !== e_off || a_miss !== e_miss || a_ov !== e_ov || a_rv !== e_rv) begin
      fails++;
      $display("FAIL %s: got rv=%0b cs=%b off=%h miss=%0b ov=%0b, want rv=%0b cs=%b off=%h miss=%0b ov=%0b",
               req, a_rv, a_cs, a_off, a_miss, a_ov, e_rv, e_cs, e_off, e_miss, e_ov);
    end
  endtask

  task automatic expect_for(logic [31:0] a, output logic [3:0] e_cs,
                            output logic [31:0] e_off, output bit e_miss, output bit e_ov);
    int n = 0;
    e_cs = 0; e_off = 0;
    for (int i = 0; i < 4; i++) begin
      longint unsigned sz = 64'd4096 << m_code[i];
      bit h = m_en[i] && m_code[i] <= 20 && ((longint'(a) / sz) == (longint'(m_base[i]) / sz));
      if (h) begin
        if (n == 0) begin
          e_cs[i] = 1'b1;
          e_off = 32'(longint'(a) % sz);
        end
        n++;
      end
    end
    e_miss = (n == 0);
    e_ov = (n > 1);
  endtask

  task automatic model_wr(int idx, logic [31:0] d);
    m_base[idx] = {d[31:12], 12'h0};
    m_code[idx] = int'(d[5:1]);
    m_en[idx]   = d[0];
  endtask

  task automatic wr(int idx, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 2'(idx); cfg_data = d;
    @(negedge clk);
    cfg_we = 0;
    model_wr(idx, d);
  endtask

  task automatic look(string req, logic [31:0] a);
    logic [3:0] e_cs; logic [31:0] e_off; bit e_miss, e_ov;
    @(negedge clk);
    lookup_valid = 1; lookup_addr = a;
    expect_for(a, e_cs, e_off, e_miss, e_ov);
    @(negedge clk);
    lookup_valid = 0;
    check(req, cs, offset, miss, overlap, res_valid, e_cs, e_off, e_miss, e_ov, 1'b1);
  endtask

  function automatic logic [31:0] word(logic [31:0] base, int code, bit en);
    return {base[31:12], 6'h0, 5'(code), en};
  endfunction

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++; checks++;
        $display("FAIL watchdog: got timeout, want completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_base[i] = 0; m_code[i] = 0; m_en[i] = 0; end
    repeat (3) @(negedge clk);
    // R1: reset state, all outputs zero
    check("R1", cs, offset, miss, overlap, res_valid, 4'b0, 32'h0, 1'b0, 1'b0, 1'b0);
    rst_n = 1;
    look("R1 no region enabled", 32'h0000_0000);
    look("R1 no region enabled", 32'hFFFF_FFFF);

    // R3 R5 R6 R10: sweep every size code on region 0 (codes above 20 -> R5)
    for (int c = 0; c < 32; c++) begin
      longint unsigned sz = 64'd4096 << (c > 20 ? 20 : c);
      logic [31:0] b = 32'hA5C3_7000;
      logic [31:0] lo = 32'((longint'(b) / sz) * sz);
      string tag = c > 20 ? "R5" : (c == 20 ? "R10" : "R3");
      wr(0, word(b, c, 1'b1));
      look(tag, lo);
      look(tag, 32'(longint'(lo) + sz - 1));
      look(tag, 32'(longint'(lo) + sz));
      look(tag, lo - 32'd1);
      look("R6 offset", lo + 32'h0000_0ABC);
    end

    // R4: enable clear never matches
    wr(0, word(32'h1000_0000, 4, 1'b0));
    look("R4", 32'h1000_0000);
    look("R4", 32'h1000_FFFF);

    // R2: ignored bits 11:6 and low base bits
    wr(1, word(32'h2000_0000, 2, 1'b1) | 32'h0000_0FC0);
    look("R2 ignored bits", 32'h2000_3FFF);
    look("R2 ignored bits", 32'h2000_4000);

    // R7: overlapping regions, lowest index wins
    wr(0, word(32'h8000_0000, 8, 1'b1));
    wr(2, word(32'h8000_0000, 12, 1'b1));
    wr(3, word(32'h0000_0000, 20, 1'b1));
    look("R7 three overlap", 32'h8000_0123);
    look("R7 two overlap", 32'h8010_0000);
    look("R7 one vs full", 32'h2000_0010);
    wr(3, word(32'h0, 20, 1'b0));
    look("R7 single", 32'h8010_0000);
    look("R8 miss", 32'h9000_0000);

    // R9: idle cycle clears results
    @(negedge clk);
    check("R9 idle", cs, offset, miss, overlap, res_valid, 4'b0, 32'h0, 1'b0, 1'b0, 1'b0);

    // R2: write and lookup in the same cycle sees old contents, next cycle new
    begin
      logic [3:0] e_cs; logic [31:0] e_off; bit e_miss, e_ov;
      @(negedge clk);
      cfg_we = 1; cfg_idx = 2'd1; cfg_data = word(32'h9000_0000, 0, 1'b1);
      lookup_valid = 1; lookup_addr = 32'h9000_0040;
      expect_for(32'h9000_0040, e_cs, e_off, e_miss, e_ov);
      @(negedge clk);
      cfg_we = 0; lookup_valid = 0;
      model_wr(1, word(32'h9000_0000, 0, 1'b1));
      check("R2 same-cycle old", cs, offset, miss, overlap, res_valid, e_cs, e_off, e_miss, e_ov, 1'b1);
      look("R2 next-cycle new", 32'h9000_0040);
    end

    // R3 R6 R7: sweep addresses across a mixed configuration
    wr(0, word(32'h0004_0000, 6, 1'b1));
    wr(1, word(32'h0000_0000, 9, 1'b1));
    wr(2, word(32'h0010_0000, 3, 1'b1));
    wr(3, word(32'h0000_0000, 21, 1'b1));
    for (int k = 0; k < 160; k++) look("R6 sweep", 32'(k) * 32'h0000_3100);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule